// File: doc/BRIEF.md
# Strap-Addressed Two-Wire Bus Slave

This block is the target-side front end of a two-wire serial management bus (SMBus/I2C). It watches the clock and data lines and detects START and STOP conditions. It takes transactions addressed to it and turns them into accesses on a simple internal register port. That port has a byte pointer, a write strobe with write data, and a read-data input that the surrounding logic drives with the byte at the pointer.

The 7-bit device address has a fixed five-bit base, 01011. Its two low bits come from a strap pin that can be grounded, tied to supply, or left floating. The strap level arrives as a 2-bit code and is captured once after reset.

The slave pulls the data line low through an output enable; the board supplies the pull-up. If the clock line stays low during a transaction for longer than a configurable number of cycles, the interface drops back to idle and waits for a fresh START. There is no run or shutdown input, so the bus is served in every operating state of the host chip.

Top module: `smb_strap_slave`

## Requirements
- R1: While reset is held, and after it is released, `sda_oe` is 0, `reg_wr` is 0 and `reg_ptr` is 0.
- R2: The device address is 01011 followed by XY. XY is set by the strap code on `strap_lvl`: 2'b00 (grounded) gives XY=10, 2'b01 (tied to supply) gives XY=01, and 2'b10 or 2'b11 (floating) gives XY=00. The slave acknowledges a matching address byte by driving `sda_oe`=1 during the ninth clock. The address byte is sent MSB first, with the read/write bit last (1 = read).
- R3: A non-matching address is never acknowledged, and address 0101111 is never acknowledged for any strap. After a non-matching address the slave keeps `sda_oe`=0 until the next START or STOP.
- R4: The strap code is sampled once, in the first cycle after reset is released. Later changes on `strap_lvl` have no effect until the next reset.
- R5: In a write, the byte that follows the address is acknowledged and loaded into `reg_ptr`.
- R6: Each later byte of a write is acknowledged. It produces a one-cycle `reg_wr` pulse, with `reg_wdata` holding the byte and `reg_ptr` holding the target. `reg_ptr` then advances by one.
- R7: In a read, the slave shifts out `reg_rdata`, MSB first, with `sda_oe`=1 for each 0 bit. `reg_ptr` advances after every byte sent. A master ACK (data low on the ninth clock) starts the next byte. A NACK makes the slave release the line until the next START or STOP.
- R8: A falling data line while the clock is high is a START. A rising data line while the clock is high is a STOP. A STOP in any state, even mid-byte, returns the slave to idle: the line is released and no partial byte is written. A repeated START restarts the address phase.
- R9: If the clock line stays low for `TIMEOUT_CYC` consecutive cycles while a transaction is in progress, the slave returns to idle and releases the data line. Any high clock level clears the count. After a timeout, bytes clocked without a new START are neither acknowledged nor written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_lvl | input | 2 | Strap pin level code (00 ground, 01 supply, 10/11 floating) |
| reg_ptr | output | 8 | Register pointer |
| reg_wdata | output | 8 | Write data, valid with reg_wr |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Byte at reg_ptr, supplied by the register file |

## Verification
The bench builds the block with `TIMEOUT_CYC` set to 300 and the default two-stage line synchroniser. With that setting a clock-low hold can be placed a little below and a little above the limit within a few hundred cycles, while a normal bus bit of 24 clocks stays far below it. The 300-cycle limit brings within reach both sides of the timeout boundary and the ignored bytes that follow it. All three strap levels are covered by repeated resets, which lets the legal addresses and the forbidden XY=11 address be scanned for each strap.

// File: rtl/smb_slave_pkg.sv
// Shared types and constants for the strap-addressed bus slave.
// Assumes byte-wide transfers and a 7-bit address with a fixed 5-bit base.
package smb_slave_pkg;

    localparam int BYTE_W = 8;
    localparam logic [4:0] ADDR_BASE = 5'b01011;

    // Strap level codes on the strap input
    localparam logic [1:0] STRAP_GND  = 2'b00;
    localparam logic [1:0] STRAP_VCC  = 2'b01;
    localparam logic [1:0] STRAP_OPEN = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_MACK,
        ST_WAIT
    } xfer_state_t;

    // Map a strap level code to the two low address bits; never yields 2'b11
    function automatic logic [1:0] strap_to_xy(input logic [1:0] lvl);
        case (lvl)
            STRAP_GND: strap_to_xy = 2'b10;
            STRAP_VCC: strap_to_xy = 2'b01;
            default:   strap_to_xy = 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
// Synchronises the bus clock and data lines into the system clock domain
// and reports clock edges plus START/STOP conditions as one-cycle pulses.
// Assumes both lines idle high; SYNC_STAGES must be at least 2.
module smb_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    generate
        if (SYNC_STAGES == 2) begin : g_two
            // Two-flop synchroniser chain for both lines
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[0], scl_i};
                    sda_pipe <= {sda_pipe[0], sda_i};
                end
            end
        end else begin : g_deep
            // Longer synchroniser chain for both lines
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    // Previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_strap_latch.sv
// Captures the strap level once after reset and holds the two low address
// bits. Assumes the strap input is stable at reset release.
module smb_strap_latch
    import smb_slave_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap_lvl,
    output logic [1:0] dev_xy,
    output logic       xy_valid
);

    // Sample the strap in the first cycle out of reset, then freeze
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_xy   <= 2'b00;
            xy_valid <= 1'b0;
        end else if (!xy_valid) begin
            dev_xy   <= strap_to_xy(strap_lvl);
            xy_valid <= 1'b1;
        end
    end

    a_r4_xy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        xy_valid |=> $stable(dev_xy));

    a_r2_xy_legal: assert property (@(posedge clk) disable iff (!rst_n)
        xy_valid |-> (dev_xy != 2'b11));

endmodule

// File: rtl/smb_scl_timeout.sv
// Counts consecutive clock-line-low cycles during a transaction and pulses
// hit when TIMEOUT_CYC is reached. Assumes the FSM leaves busy on hit.
module smb_scl_timeout #(
    parameter int TIMEOUT_CYC = 3_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic busy,
    output logic hit
);

    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

    logic [CNT_W-1:0] low_cnt;

    assign hit = busy && !scl_s && (low_cnt == LAST);

    // Low-time counter, cleared by a high clock line or an idle bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (scl_s || !busy || hit) begin
            low_cnt <= '0;
        end else begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    a_r9_high_clears: assert property (@(posedge clk) disable iff (!rst_n)
        scl_s |=> (low_cnt == '0));

    a_r9_hit_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($past(!scl_s) || low_cnt == '0));

endmodule

// File: rtl/smb_xfer_fsm.sv
// Bit and byte engine of the slave: address match, pointer load, write
// strobes, read shifting and acknowledge handling. Assumes synchronised
// line levels and single-cycle event pulses from smb_line_sync.
module smb_xfer_fsm
    import smb_slave_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              timeout_hit,
    input  logic [1:0]        dev_xy,
    input  logic              xy_valid,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] reg_ptr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_wr,
    output logic              busy
);

    localparam int BIT_W = $clog2(BYTE_W + 1);
    localparam logic [BIT_W-1:0] FULL = BIT_W'(BYTE_W);
    localparam logic [BIT_W-1:0] LAST_OUT = BIT_W'(BYTE_W - 1);

    xfer_state_t       st;
    xfer_state_t       after_ack;
    logic [BYTE_W-1:0] sh;
    logic [BIT_W-1:0]  bit_cnt;
    logic              bump;
    logic              mack;
    logic              addr_hit;

    assign addr_hit = xy_valid && (sh[7:3] == ADDR_BASE) && (sh[2:1] == dev_xy);
    assign busy     = (st != ST_IDLE);

    // Main transaction state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            after_ack <= ST_IDLE;
            sh        <= '0;
            bit_cnt   <= '0;
            bump      <= 1'b0;
            mack      <= 1'b0;
            sda_oe    <= 1'b0;
            reg_ptr   <= '0;
            reg_wdata <= '0;
            reg_wr    <= 1'b0;
        end else begin
            reg_wr <= 1'b0;
            if (stop_det || timeout_hit) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_det) begin
                st      <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR, ST_PTR, ST_WDATA: begin
                        if (scl_rise && bit_cnt != FULL) begin
                            sh      <= {sh[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == FULL) begin
                            bit_cnt <= '0;
                            if (st == ST_ADDR) begin
                                bump <= 1'b0;
                                if (addr_hit) begin
                                    sda_oe    <= 1'b1;
                                    st        <= ST_ACK;
                                    after_ack <= sh[0] ? ST_RDATA : ST_PTR;
                                end else begin
                                    st <= ST_WAIT;
                                end
                            end else if (st == ST_PTR) begin
                                reg_ptr   <= sh;
                                bump      <= 1'b0;
                                sda_oe    <= 1'b1;
                                st        <= ST_ACK;
                                after_ack <= ST_WDATA;
                            end else begin
                                reg_wr    <= 1'b1;
                                reg_wdata <= sh;
                                bump      <= 1'b1;
                                sda_oe    <= 1'b1;
                                st        <= ST_ACK;
                                after_ack <= ST_WDATA;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bump    <= 1'b0;
                            bit_cnt <= '0;
                            if (bump) begin
                                reg_ptr <= reg_ptr + 1'b1;
                            end
                            if (after_ack == ST_RDATA) begin
                                sh     <= reg_rdata;
                                sda_oe <= ~reg_rdata[BYTE_W-1];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                            st <= after_ack;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (bit_cnt == LAST_OUT) begin
                                sda_oe  <= 1'b0;
                                reg_ptr <= reg_ptr + 1'b1;
                                st      <= ST_MACK;
                            end else begin
                                sh      <= {sh[BYTE_W-2:0], 1'b0};
                                sda_oe  <= ~sh[BYTE_W-2];
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                sh      <= reg_rdata;
                                sda_oe  <= ~reg_rdata[BYTE_W-1];
                                bit_cnt <= '0;
                                st      <= ST_RDATA;
                            end else begin
                                st <= ST_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    a_r6_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    a_r8_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == ST_IDLE && !sda_oe));

    a_r8_start_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !stop_det && !timeout_hit) |=> (st == ST_ADDR && bit_cnt == '0));

    a_r9_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_hit |=> (st == ST_IDLE && !sda_oe));

    a_r3_never_11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ADDR && scl_fall && bit_cnt == FULL && sh[2:1] == 2'b11
         && !start_det && !stop_det && !timeout_hit) |=> !sda_oe);

    a_r3_wait_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> !sda_oe);

endmodule

// File: rtl/smb_strap_slave.sv
// Top of the strap-addressed two-wire bus slave. Ties together the line
// synchroniser, strap latch, clock-low timeout and transaction engine.
// Assumes an external pull-up; sda_oe=1 means the data line is pulled low.
module smb_strap_slave #(
    parameter int TIMEOUT_CYC = 3_500_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] strap_lvl,
    output logic [7:0] reg_ptr,
    output logic [7:0] reg_wdata,
    output logic       reg_wr,
    input  logic [7:0] reg_rdata
);

    logic       scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [1:0] dev_xy;
    logic       xy_valid;
    logic       busy;
    logic       timeout_hit;

    smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smb_strap_latch u_strap (
        .clk(clk), .rst_n(rst_n), .strap_lvl(strap_lvl),
        .dev_xy(dev_xy), .xy_valid(xy_valid)
    );

    smb_scl_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmo (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .busy(busy), .hit(timeout_hit)
    );

    smb_xfer_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .timeout_hit(timeout_hit), .dev_xy(dev_xy), .xy_valid(xy_valid),
        .reg_rdata(reg_rdata), .sda_oe(sda_oe), .reg_ptr(reg_ptr),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .busy(busy)
    );

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && !reg_wr && reg_ptr == 8'd0));

endmodule

// File: tb/smb_strap_slave_tb_top.sv
module smb_strap_slave_tb_top;

    localparam int TMO = 300;
    localparam int Q   = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] strap_lvl = 2'b00;
    logic       sda_oe;
    logic [7:0] reg_ptr, reg_wdata, reg_rdata;
    logic       reg_wr;
    wire        sda_bus = m_sda & ~sda_oe;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    int         wr_count = 0;
    int         errors = 0;
    int         checks = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    smb_strap_slave #(.TIMEOUT_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .strap_lvl(strap_lvl), .reg_ptr(reg_ptr),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = mem[reg_ptr];

    always @(posedge clk) begin
        if (reg_wr) begin
            mem[reg_ptr] <= reg_wdata;
            wr_count <= wr_count + 1;
        end
    end

    function automatic logic [6:0] exp_addr(input logic [1:0] s);
        logic [1:0] xy;
        xy = (s == 2'b00) ? 2'b10 : (s == 2'b01) ? 2'b01 : 2'b00;
        return {5'b01011, xy};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wq(Q); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) send_bit(v[i]);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        send_bits(v, 8);
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        ack = ~sda_bus;
        wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
            v[i] = sda_bus;
            wq(Q); m_scl = 1'b0; wq(Q);
        end
        send_bit(~give_ack);
    endtask

    task automatic do_reset(input logic [1:0] s);
        strap_lvl = s;
        m_scl = 1'b1; m_sda = 1'b1;
        rst_n = 1'b0; wq(4);
        check("R1 sda_oe in reset", sda_oe, 0);
        rst_n = 1'b1; wq(4);
        check("R1 reg_ptr after reset", reg_ptr, 0);
        check("R1 reg_wr after reset", reg_wr, 0);
    endtask

    task automatic probe_addr(input logic [6:0] a, input logic exp_ack, input string req);
        logic ack;
        bus_start();
        send_byte({a, 1'b0}, ack);
        check(req, ack, exp_ack);
        check({req, " released after nack"}, sda_oe, 0);
        bus_stop();
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] p, input int n);
        logic ack;
        logic [7:0] d;
        int w0;
        w0 = wr_count;
        bus_start();
        send_byte({a, 1'b0}, ack);
        check("R2 write address ack", ack, 1);
        send_byte(p, ack);
        check("R5 pointer ack", ack, 1);
        check("R5 pointer loaded", reg_ptr, p);
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            send_byte(d, ack);
            check("R6 data ack", ack, 1);
            exp_mem[8'(p + i)] = d;
        end
        bus_stop();
        wq(2);
        check("R6 strobe count", wr_count - w0, n);
        check("R6 pointer advanced", reg_ptr, 8'(p + n));
        for (int i = 0; i < n; i++)
            check("R6 stored byte", mem[8'(p + i)], exp_mem[8'(p + i)]);
    endtask

    task automatic do_read(input logic [6:0] a, input logic [7:0] p, input int n);
        logic ack;
        logic [7:0] v;
        bus_start();
        send_byte({a, 1'b0}, ack);
        send_byte(p, ack);
        bus_start();
        send_byte({a, 1'b1}, ack);
        check("R8 repeated start read address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, v);
            check("R7 read byte", v, exp_mem[8'(p + i)]);
        end
        check("R7 released after nack", sda_oe, 0);
        bus_stop();
        check("R7 pointer advanced", reg_ptr, 8'(p + n));
    endtask

    initial begin
        logic [1:0] straps [3];
        logic [6:0] me;
        logic ack;
        logic [7:0] p;
        int w0;
        void'($urandom(32'd2024));
        straps[0] = 2'b00; straps[1] = 2'b01; straps[2] = 2'b10;
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i ^ 8'h5A);
            exp_mem[i] = 8'(i ^ 8'h5A);
        end

        for (int s = 0; s < 3; s++) begin
            do_reset(straps[s]);
            me = exp_addr(straps[s]);
            for (int x = 0; x < 4; x++) begin
                probe_addr({5'b01011, 2'(x)}, ({5'b01011, 2'(x)} == me),
                           (x == 3) ? "R3 address 0101111" : "R2 address scan");
            end
            probe_addr(7'(me ^ 7'h40), 1'b0, "R3 wrong base");
            strap_lvl = straps[(s + 1) % 3];
            probe_addr(me, 1'b1, "R4 strap change ignored");
            probe_addr(exp_addr(straps[(s + 1) % 3]), 1'b0, "R4 new strap not used");
            for (int t = 0; t < 3; t++) begin
                p = 8'($urandom);
                do_write(me, p, 1 + int'($urandom % 3));
                do_read(me, p, 2);
            end
        end

        // Floating code 11 behaves as floating
        do_reset(2'b11);
        probe_addr(7'b0101100, 1'b1, "R2 strap 11 floating");
        me = 7'b0101100;

        // R8: STOP mid data byte writes nothing
        p = 8'h40;
        w0 = wr_count;
        bus_start();
        send_byte({me, 1'b0}, ack);
        send_byte(p, ack);
        send_bits(8'h00, 4);
        bus_stop();
        check("R8 no write on mid-byte stop", wr_count - w0, 0);
        check("R8 stop released", sda_oe, 0);
        // R8: repeated start after a rejected address
        bus_start();
        send_byte({7'b0101111, 1'b0}, ack);
        check("R8 rejected first", ack, 0);
        bus_start();
        send_byte({me, 1'b0}, ack);
        check("R8 repeated start accepted", ack, 1);
        bus_stop();

        // R9: clock held low during the address acknowledge
        bus_start();
        send_bits({me, 1'b0}, 8);
        wq(TMO - 40);
        check("R9 below limit still acking", sda_oe, 1);
        wq(80);
        check("R9 timeout released", sda_oe, 0);
        w0 = wr_count;
        send_byte(8'h10, ack);
        check("R9 no ack after timeout", ack, 0);
        send_byte(8'hAB, ack);
        check("R9 no write after timeout", wr_count - w0, 0);
        bus_stop();
        probe_addr(me, 1'b1, "R9 new transaction after timeout");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule